// File: doc/BRIEF.md
# Bridge I/O Window Forwarding Decoder

This block belongs to a two-port bus bridge. It keeps the configuration registers that place one I/O address window behind the bridge, and for each transaction it reports whether the bridge should claim that transaction and carry it across. A transaction seen on the primary side and falling inside the window travels downstream. An I/O transaction seen on the secondary side and falling outside the window travels upstream. A secondary-side memory transaction always travels upstream. Two command bits gate the directions: an I/O enable for downstream traffic and a master enable for upstream traffic.

The window is placed with 4 KB granularity. Its lower bound comes from a 4-bit field in the low configuration dword plus a 16-bit upper register; the lower bound's bottom twelve address bits are taken as zero. Its upper bound is built the same way, and its bottom twelve bits are taken as all ones. When the lower bound is above the upper bound, the window is switched off.

Configuration access is by byte offset with four byte enables, one per byte of the addressed dword. The decision is registered, so it appears one clock after the transaction is presented.

Top module: `iowin_decoder`

## Requirements
- R1: After reset both window registers hold zero in every writable field. The window then covers exactly 0000_0000h to 0000_0FFFh: a primary I/O access at 0000_0ABCh is claimed, and one at 0000_1000h is not.
- R2: Byte 1Ch holds the lower-bound bits [15:12] in its bits [7:4]. Byte 1Dh holds the upper-bound bits [15:12] in its bits [7:4]. Bits [3:0] of both bytes always read 1h, and writes to those bits have no effect.
- R3: The dword at 30h holds the lower-bound bits [31:16] in data bits [15:0] and the upper-bound bits [31:16] in data bits [31:16]; all of these bits are read/write. A write changes only the bytes whose enable bit is set, where byte enable bit n selects data bits [8n+7:8n]. Bytes 1Eh and 1Fh and every other dword offset read as zero, and writes to them change nothing.
- R4: The lower bound is {hi16, nibble, 000h} and the upper bound is {hi16, nibble, FFFh}. Both limits are inclusive, and the comparison is unsigned over all 32 bits.
- R5: A primary-side I/O transaction drives fwd_down high only when io_en is 1 and the address lies in the window. With io_en at 0, no primary-side transaction is claimed.
- R6: A secondary-side I/O transaction drives fwd_up high only when mst_en is 1 and the address lies outside the window. With mst_en at 0, no secondary-side transaction is claimed.
- R7: When the lower bound exceeds the upper bound, fwd_down never asserts, and every secondary-side I/O transaction goes upstream if mst_en is 1. This holds whether the inversion is in the nibble or in the upper 16 bits.
- R8: A secondary-side memory transaction (txn_is_io=0) drives fwd_up exactly when mst_en is 1, whatever the window holds. A primary-side memory transaction is never claimed by this block.
- R9: The decision is registered. The outputs reflect the transaction presented at the previous rising edge, and both outputs are 0 after an edge with txn_valid at 0. A configuration write takes effect at its edge, so a transaction presented in the same cycle is decided with the old window.
- R10: fwd_down and fwd_up are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_offset | input | 8 | Configuration byte offset; bits [1:0] are ignored |
| cfg_be | input | 4 | Byte enables of the addressed dword |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data of the addressed dword (combinational) |
| io_en | input | 1 | Command I/O enable, gates downstream forwarding |
| mst_en | input | 1 | Command master enable, gates upstream forwarding |
| txn_valid | input | 1 | A transaction address is presented this cycle |
| txn_addr | input | 32 | Transaction address |
| txn_from_sec | input | 1 | 1 = transaction seen on secondary side, 0 = primary side |
| txn_is_io | input | 1 | 1 = I/O transaction, 0 = memory transaction |
| fwd_down | output | 1 | Registered: claim and forward downstream |
| fwd_up | output | 1 | Registered: claim and forward upstream |

## Verification
The bench probes both inclusive edges of the window (first byte of the lower 4 KB block, last byte of the upper one) and the addresses just past each edge. A compare that was off by one, or that filled the wrong implied low bits, would flip the claim at exactly one of those four addresses. It turns the window off twice, once through the nibble and once through the upper 16 bits, so a compare that ignored either half would still claim downstream. It also presents a transaction in the same cycle as a write that moves the window, and drives partial byte-enable writes and writes to read-only and unmapped bytes. Wrong write timing would decide that transaction with the new window, and a wrong lane decode would corrupt neighbouring bytes or the read-only capability nibble.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

   // registered claim decision for one transaction
   typedef struct packed {
      logic down;
      logic up;
   } fwd_t;

   localparam fwd_t FWD_NONE = '{down: 1'b0, up: 1'b0};

   // bytes per configuration dword
   localparam int unsigned CFG_LANES = 4;

endpackage

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned GRAN_W = 12,
   parameter int unsigned OFS_W  = 8,
   parameter logic [OFS_W-1:0] OFS_LO = 'h1C,
   parameter logic [OFS_W-1:0] OFS_HI = 'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [OFS_W-1:0]  cfg_offset,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] lim_addr
);
   localparam int unsigned NIB_W  = 16 - GRAN_W;
   localparam int unsigned CAP_W  = 8 - NIB_W;
   localparam bit          HAS_HI = (ADDR_W > 16);
   localparam int unsigned HI_W   = HAS_HI ? ADDR_W - 16 : 1;
   localparam int unsigned DW_W   = OFS_W - 2;
   localparam logic [CAP_W-1:0] CAP_CODE = HAS_HI ? CAP_W'(1) : '0;

   if (ADDR_W != 16 && ADDR_W != 32) begin : g_bad_addr_w
      $error("iowin_cfg_regs: ADDR_W must be 16 or 32");
   end
   if (GRAN_W < 8 || GRAN_W > 15) begin : g_bad_gran_w
      $error("iowin_cfg_regs: GRAN_W must lie in 8..15");
   end
   if (OFS_W < 3) begin : g_bad_ofs_w
      $error("iowin_cfg_regs: OFS_W too small");
   end
   if (OFS_LO[OFS_W-1:2] == OFS_HI[OFS_W-1:2]) begin : g_bad_ofs
      $error("iowin_cfg_regs: register dwords overlap");
   end

   logic [DW_W-1:0]  dw_sel;
   logic             hit_lo;
   logic             hit_hi;
   logic [NIB_W-1:0] base_nib_q;
   logic [NIB_W-1:0] lim_nib_q;
   logic [31:0]      lo_rd;
   logic [31:0]      hi_rd;
   logic             unused_cfg;

   assign dw_sel     = cfg_offset[OFS_W-1:2];
   assign hit_lo     = (dw_sel == OFS_LO[OFS_W-1:2]);
   assign hit_hi     = HAS_HI && (dw_sel == OFS_HI[OFS_W-1:2]);
   assign unused_cfg = ^{cfg_offset[1:0], cfg_wdata, cfg_be};

   // nibble fields in the low dword: byte 0 lower bound, byte 1 upper bound
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_nib_q <= '0;
         lim_nib_q  <= '0;
      end else if (cfg_wr && hit_lo) begin
         if (cfg_be[0]) base_nib_q <= cfg_wdata[7 -: NIB_W];
         if (cfg_be[1]) lim_nib_q  <= cfg_wdata[15 -: NIB_W];
      end
   end

   assign lo_rd = {16'h0000, lim_nib_q, CAP_CODE, base_nib_q, CAP_CODE};

   if (HAS_HI) begin : g_hi
      localparam int unsigned HI_LANES = (2 * HI_W) / 8;
      logic [2*HI_W-1:0] hi_q;

      for (genvar ln = 0; ln < HI_LANES; ln++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q[8*ln +: 8] <= '0;
            end else if (cfg_wr && hit_hi && cfg_be[ln]) begin
               hi_q[8*ln +: 8] <= cfg_wdata[8*ln +: 8];
            end
         end
      end

      assign base_addr = {hi_q[HI_W-1:0], base_nib_q, {GRAN_W{1'b0}}};
      assign lim_addr  = {hi_q[2*HI_W-1:HI_W], lim_nib_q, {GRAN_W{1'b1}}};
      assign hi_rd     = 32'(hi_q);
   end else begin : g_no_hi
      assign base_addr = {base_nib_q, {GRAN_W{1'b0}}};
      assign lim_addr  = {lim_nib_q, {GRAN_W{1'b1}}};
      assign hi_rd     = '0;
   end

   always_comb begin
      if (hit_lo)      cfg_rdata = lo_rd;
      else if (hit_hi) cfg_rdata = hi_rd;
      else             cfg_rdata = '0;
   end

endmodule

// File: rtl/iowin_range_cmp.sv
module iowin_range_cmp #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [ADDR_W-1:0] lim_addr,
   output logic              win_on,
   output logic              in_win
);
   if (ADDR_W < 2) begin : g_bad_w
      $error("iowin_range_cmp: ADDR_W too small");
   end

   logic above_base;
   logic below_lim;

   assign win_on     = (base_addr <= lim_addr);
   assign above_base = (addr >= base_addr);
   assign below_lim  = (addr <= lim_addr);
   assign in_win     = win_on && above_base && below_lim;

endmodule

// File: rtl/iowin_fwd_decide.sv
module iowin_fwd_decide
   import iowin_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic txn_valid,
   input  logic txn_from_sec,
   input  logic txn_is_io,
   input  logic io_en,
   input  logic mst_en,
   input  logic in_win,
   output logic fwd_down,
   output logic fwd_up
);
   fwd_t nxt;
   fwd_t cur_q;

   always_comb begin
      nxt = FWD_NONE;
      if (txn_valid) begin
         if (!txn_from_sec) begin
            nxt.down = txn_is_io && io_en && in_win;
         end else if (mst_en) begin
            nxt.up = !txn_is_io || !in_win;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= FWD_NONE;
      else        cur_q <= nxt;
   end

   assign fwd_down = cur_q.down;
   assign fwd_up   = cur_q.up;

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned GRAN_W = 12,
   parameter int unsigned OFS_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [OFS_W-1:0]  cfg_offset,
   input  logic [3:0]        cfg_be,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   input  logic              io_en,
   input  logic              mst_en,
   input  logic              txn_valid,
   input  logic [ADDR_W-1:0] txn_addr,
   input  logic              txn_from_sec,
   input  logic              txn_is_io,
   output logic              fwd_down,
   output logic              fwd_up
);
   logic [ADDR_W-1:0] base_addr;
   logic [ADDR_W-1:0] lim_addr;
   logic              win_on;
   logic              in_win;
   logic              unused_win;

   assign unused_win = win_on;

   iowin_cfg_regs #(
      .ADDR_W (ADDR_W),
      .GRAN_W (GRAN_W),
      .OFS_W  (OFS_W),
      .OFS_LO (OFS_W'('h1C)),
      .OFS_HI (OFS_W'('h30))
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_offset (cfg_offset),
      .cfg_be     (cfg_be),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .base_addr  (base_addr),
      .lim_addr   (lim_addr)
   );

   iowin_range_cmp #(
      .ADDR_W (ADDR_W)
   ) u_cmp (
      .addr      (txn_addr),
      .base_addr (base_addr),
      .lim_addr  (lim_addr),
      .win_on    (win_on),
      .in_win    (in_win)
   );

   iowin_fwd_decide u_decide (
      .clk          (clk),
      .rst_n        (rst_n),
      .txn_valid    (txn_valid),
      .txn_from_sec (txn_from_sec),
      .txn_is_io    (txn_is_io),
      .io_en        (io_en),
      .mst_en       (mst_en),
      .in_win       (in_win),
      .fwd_down     (fwd_down),
      .fwd_up       (fwd_up)
   );

endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OFS_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OFS_W-1:0]  cfg_offset,
   input logic [31:0]       cfg_rdata,
   input logic              io_en,
   input logic              mst_en,
   input logic              txn_valid,
   input logic              txn_from_sec,
   input logic              txn_is_io,
   input logic              fwd_down,
   input logic              fwd_up
);
   localparam logic [3:0] CAP = (ADDR_W > 16) ? 4'h1 : 4'h0;
   logic [OFS_W-3:0] dw;
   assign dw = cfg_offset[OFS_W-1:2];

   // R2: capability nibbles always read back fixed
   assert_cap_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dw == OFS_W'('h1C) >> 2) |-> (cfg_rdata[3:0] == CAP && cfg_rdata[11:8] == CAP));

   // R3: unmapped dwords read zero
   assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dw != OFS_W'('h1C) >> 2 && dw != OFS_W'('h30) >> 2) |-> (cfg_rdata == 32'h0));

   // R5: no downstream claim without I/O enable
   assert_down_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !io_en) |=> !fwd_down);

   // R5: downstream claims only come from primary-side I/O
   assert_down_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && (txn_from_sec || !txn_is_io)) |=> !fwd_down);

   // R6: no upstream claim without master enable, nor from the primary side
   assert_up_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && (!mst_en || !txn_from_sec)) |=> !fwd_up);

   // R8: secondary memory always goes up when mastering is enabled
   assert_mem_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_from_sec && !txn_is_io && mst_en) |=> fwd_up);

   // R9: idle cycle yields no claim
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> (!fwd_down && !fwd_up));

   // R10: never both directions
   assert_one_dir_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fwd_down, fwd_up}));

endmodule

bind iowin_decoder iowin_decoder_chk #(
   .ADDR_W (ADDR_W),
   .OFS_W  (OFS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_offset   (cfg_offset),
   .cfg_rdata    (cfg_rdata),
   .io_en        (io_en),
   .mst_en       (mst_en),
   .txn_valid    (txn_valid),
   .txn_from_sec (txn_from_sec),
   .txn_is_io    (txn_is_io),
   .fwd_down     (fwd_down),
   .fwd_up       (fwd_up)
);

// File: tb/test_iowin_decoder.sv
`timescale 1ns/1ps
module test_iowin_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_offset = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        io_en = 1'b0;
   logic        mst_en = 1'b0;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        txn_from_sec = 1'b0;
   logic        txn_is_io = 1'b0;
   logic        fwd_down;
   logic        fwd_up;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   iowin_decoder i_iowin_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_offset(cfg_offset),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .io_en(io_en), .mst_en(mst_en), .txn_valid(txn_valid), .txn_addr(txn_addr),
      .txn_from_sec(txn_from_sec), .txn_is_io(txn_is_io),
      .fwd_down(fwd_down), .fwd_up(fwd_up));

   // {from_sec, is_io, io_en, mst_en, addr[31:0], exp_down, exp_up}
   // window 1234_5000h .. 1234_7FFFh
   localparam logic [37:0] VECS [0:11] = '{
      {4'b0110, 32'h1234_5000, 2'b10},   // R4 R5 lower edge inclusive
      {4'b0110, 32'h1234_7FFF, 2'b10},   // R4 R5 upper edge inclusive
      {4'b0110, 32'h1234_4FFF, 2'b00},   // R4 just below
      {4'b0110, 32'h1234_8000, 2'b00},   // R4 just above
      {4'b0101, 32'h1234_6000, 2'b00},   // R5 io_en clear
      {4'b1101, 32'h1234_4FFF, 2'b01},   // R6 outside goes up
      {4'b1101, 32'h1234_6000, 2'b00},   // R6 inside stays
      {4'b1110, 32'h0000_0000, 2'b00},   // R6 mst_en clear
      {4'b1001, 32'h1234_6000, 2'b01},   // R8 memory up regardless of window
      {4'b1010, 32'h0000_0000, 2'b00},   // R8 memory, mst_en clear
      {4'b0011, 32'h1234_6000, 2'b00},   // R8 primary memory not claimed
      {4'b1101, 32'hFFFF_FFFF, 2'b01}    // R6 top of space
   };

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] ofs, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_offset = ofs; cfg_be = be; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic cfg_read(input string req, input logic [7:0] ofs, input logic [31:0] exp);
      @(negedge clk);
      cfg_offset = ofs;
      #1 chk(req, cfg_rdata, exp);
   endtask

   task automatic txn(input string req, input logic sec, input logic io, input logic ioe,
                      input logic me, input logic [31:0] a, input logic [1:0] exp);
      @(negedge clk);
      txn_valid = 1'b1; txn_from_sec = sec; txn_is_io = io;
      io_en = ioe; mst_en = me; txn_addr = a;
      @(posedge clk);
      #1 chk(req, {30'h0, fwd_down, fwd_up}, {30'h0, exp});
      @(negedge clk);
      txn_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog act=hung exp=finished");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 reset state
      @(posedge clk); #1 chk("R1 outputs after reset", {30'h0, fwd_down, fwd_up}, 32'h0);
      cfg_read("R1 R2 low dword at reset", 8'h1C, 32'h0000_0101);
      cfg_read("R1 upper dword at reset", 8'h30, 32'h0000_0000);
      txn("R1 reset window holds 0ABCh", 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0ABC, 2'b10);
      txn("R1 reset window excludes 1000h", 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_1000, 2'b00);
      txn("R1 secondary 1000h goes up", 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_1000, 2'b01);

      // program window 1234_5000h .. 1234_7FFFh, low nibbles written as ones
      cfg_write(8'h1C, 4'b0011, 32'hFFFF_7F5F);
      cfg_write(8'h30, 4'b1111, 32'h1234_1234);
      cfg_read("R2 capability nibbles ignore writes", 8'h1C, 32'h0000_7151);
      cfg_read("R3 upper dword readback", 8'h32, 32'h1234_1234);

      for (int i = 0; i < 12; i++) begin
         txn($sformatf("R4 vector %0d", i), VECS[i][37], VECS[i][36], VECS[i][35],
             VECS[i][34], VECS[i][33:2], VECS[i][1:0]);
      end

      // R3 byte lanes and unmapped space
      cfg_write(8'h30, 4'b0100, 32'hAAAA_AAAA);
      cfg_read("R3 single lane write", 8'h30, 32'h12AA_1234);
      cfg_write(8'h30, 4'b0100, 32'h0034_0000);
      cfg_write(8'h1C, 4'b1100, 32'hFFFF_0000);
      cfg_read("R3 bytes 1Eh 1Fh not writable", 8'h1C, 32'h0000_7151);
      cfg_write(8'h20, 4'b1111, 32'hFFFF_FFFF);
      cfg_read("R3 unmapped dword reads zero", 8'h20, 32'h0000_0000);
      txn("R3 window intact after stray writes", 1'b0, 1'b1, 1'b1, 1'b0, 32'h1234_7FFF, 2'b10);

      // R7 window off through the nibble
      cfg_write(8'h1C, 4'b0001, 32'h0000_0080);
      cfg_read("R7 nibble readback", 8'h1C, 32'h0000_7181);
      txn("R7 off nibble no down at limit", 1'b0, 1'b1, 1'b1, 1'b0, 32'h1234_7FFF, 2'b00);
      txn("R7 off nibble no down at base", 1'b0, 1'b1, 1'b1, 1'b0, 32'h1234_8000, 2'b00);
      txn("R7 off nibble secondary up", 1'b1, 1'b1, 1'b0, 1'b1, 32'h1234_6000, 2'b01);
      cfg_write(8'h1C, 4'b0001, 32'h0000_0050);

      // R7 window off through the upper half
      cfg_write(8'h30, 4'b0011, 32'h0000_1235);
      txn("R7 off upper no down", 1'b0, 1'b1, 1'b1, 1'b0, 32'h1235_5000, 2'b00);
      txn("R7 off upper secondary up", 1'b1, 1'b1, 1'b0, 1'b1, 32'h1234_6000, 2'b01);
      cfg_write(8'h30, 4'b0011, 32'h0000_1234);
      txn("R5 window restored", 1'b0, 1'b1, 1'b1, 1'b0, 32'h1234_5800, 2'b10);

      // R9 write in the same cycle as a transaction uses the old window
      @(negedge clk);
      cfg_wr = 1'b1; cfg_offset = 8'h1C; cfg_be = 4'b0001; cfg_wdata = 32'h0000_0060;
      txn_valid = 1'b1; txn_from_sec = 1'b0; txn_is_io = 1'b1; io_en = 1'b1;
      mst_en = 1'b0; txn_addr = 32'h1234_5800;
      @(posedge clk);
      #1 chk("R9 same-cycle write uses old window", {31'h0, fwd_down}, 32'h1);
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
      @(posedge clk);
      #1 chk("R9 new window next cycle", {31'h0, fwd_down}, 32'h0);
      @(negedge clk);
      txn_valid = 1'b0;
      @(posedge clk);
      #1 chk("R9 idle gives no claim", {30'h0, fwd_down, fwd_up}, 32'h0);
      txn("R10 secondary outside only up", 1'b1, 1'b1, 1'b1, 1'b1, 32'h1234_5800, 2'b01);

      done = 1'b1;
      report();
      $finish;
   end

endmodule